// File: doc/BRIEF.md
# Fractional Phase-Accumulator Baud Tick Generator

This block turns a fast system clock into the 16x oversampling strobe that a UART's transmit and receive engines run on. It does not divide the clock by an integer. Instead, a 16-bit phase register adds a programmable step on every enabled clock. Every time the sum wraps past 2^16, the block emits a one-cycle `tick`. The tick rate is therefore `f_clk * step / 65536`. With a 100 MHz clock, programming `step = floor(baud * 2^20 / 100e6)` gives a tick rate of about 16 x baud. Because the step is proportional to the baud rate, fine baud steps are possible, and the top rate is f_clk / 16.

Software loads the 16-bit step one byte at a time through byte-lane write strobes. Lane 0 holds bits 7:0 and lane 1 holds bits 15:8. A new step is used from the following clock edge, and the running phase is kept. While `enable` is low the phase is held at zero and no ticks occur. A one-cycle `phase_clr` restarts the phase while the block stays enabled.

Top module: `bacc_tick_gen`

## Requirements
- R1: After reset, `tick` is 0, the phase is 0 and the step is 0.
- R2: On each clock edge where `enable` is 1 and `phase_clr` is 0, phase becomes (phase + step) mod 2^16. `tick` is registered in that same edge and equals the carry out of the addition.
- R3: On an edge where `enable` is 0, the phase is cleared and `tick` goes to 0. Re-enabling starts counting from phase 0.
- R4: On an edge where `phase_clr` is 1, the phase is cleared and `tick` goes to 0, whatever the step is.
- R5: `wr_en[0]` loads `wr_data` into step bits 7:0 and `wr_en[1]` loads it into bits 15:8. The other byte is kept.
- R6: A step written on one edge is used by the addition on the next edge. The write does not disturb the phase.
- R7: A step of 0 produces no ticks.
- R8: A step of 0xFFFF, started from phase 0, produces exactly 65535 ticks in 65536 enabled cycles.
- R9: Starting from phase 0, N enabled cycles produce exactly floor(N * step / 65536) ticks. For a 115200 baud setting at 100 MHz the step is 1207, giving 1207 ticks per 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Run the accumulator; low holds the phase at zero |
| phase_clr | input | 1 | Restart the phase at zero for this cycle |
| wr_en | input | 2 | Byte-lane write strobes for the step (lane 1 = high byte) |
| wr_data | input | 8 | Byte written into the selected step lanes |
| tick | output | 1 | One-cycle oversampling strobe on accumulator carry |

## Verification
Step values at the extremes are tried: zero, 0xFFFF and the step for a real baud setting. Tick counts over a full 2^16-cycle window tell a correct wrap from an off-by-one carry or a lost bit. A directed step change in the middle of a run separates three behaviours: using the new step one edge late (correct), using it at once, and resetting the phase on the write. Single-lane writes show whether the untouched byte is kept. A long random mix of enable drops, phase clears and lane writes is compared cycle by cycle with a bench model of the phase.

// File: rtl/bacc_pkg.sv
package bacc_pkg;
  localparam int unsigned DEF_PHASE_W = 16;
  localparam int unsigned DEF_LANE_W  = 8;

  // Per-cycle control for the phase register.
  typedef struct packed {
    logic run;
    logic restart;
  } acc_ctl_t;
endpackage

// File: rtl/bacc_rst_sync.sv
module bacc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/bacc_inc_reg.sv
module bacc_inc_reg #(
  parameter int unsigned W      = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [W/LANE_W-1:0]   wr_en,
  input  logic [LANE_W-1:0]     wr_data,
  output logic [W-1:0]          inc
);
  localparam int unsigned LANES = W / LANE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_d;
    logic [LANE_W-1:0] lane_q;

    always_comb begin
      lane_d = lane_q;
      if (wr_en[g]) lane_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign inc[g*LANE_W +: LANE_W] = lane_q;
  end
endmodule

// File: rtl/bacc_phase.sv
module bacc_phase
  import bacc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  acc_ctl_t      ctl,
  input  logic [W-1:0]  inc,
  output logic [W-1:0]  acc,
  output logic          tick
);
  logic [W-1:0] acc_q, acc_d;
  logic         tick_q, tick_d;
  logic [W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_q} + {1'b0, inc};
    if (!ctl.run || ctl.restart) begin
      acc_d  = '0;
      tick_d = 1'b0;
    end else begin
      acc_d  = sum[W-1:0];
      tick_d = sum[W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign acc  = acc_q;
  assign tick = tick_q;
endmodule

// File: rtl/bacc_tick_gen.sv
module bacc_tick_gen
  import bacc_pkg::*;
#(
  parameter int unsigned W      = DEF_PHASE_W,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 phase_clr,
  input  logic [W/LANE_W-1:0]  wr_en,
  input  logic [LANE_W-1:0]    wr_data,
  output logic                 tick
);
  logic         rst_sync_n;
  logic [W-1:0] inc_w;
  logic [W-1:0] acc_w;
  acc_ctl_t     ctl;

  bacc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bacc_inc_reg #(.W(W), .LANE_W(LANE_W)) u_inc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .inc     (inc_w)
  );

  always_comb begin
    ctl.run     = enable;
    ctl.restart = phase_clr;
  end

  bacc_phase #(.W(W)) u_phase (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctl   (ctl),
    .inc   (inc_w),
    .acc   (acc_w),
    .tick  (tick)
  );
endmodule

// File: rtl/bacc_tick_gen_chk.sv
module bacc_tick_gen_chk #(
  parameter int unsigned W      = 16,
  parameter int unsigned LANE_W = 8
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 enable,
  input logic                 phase_clr,
  input logic [W/LANE_W-1:0]  wr_en,
  input logic [LANE_W-1:0]    wr_data,
  input logic                 tick,
  input logic [W-1:0]         inc,
  input logic [W-1:0]         acc
);
  // R3: disabled cycle leaves no tick and zero phase
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !enable |=> (!tick && acc == '0));

  // R4: phase restart forces a quiet cycle
  p_restart_quiet_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phase_clr |=> (!tick && acc == '0));

  // R7: zero step never carries
  p_zero_step_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (inc == '0) |=> !tick);

  // R2: a carry is seen exactly when the phase wrapped below its old value
  p_carry_wrap_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (enable && !phase_clr) |=> (tick == (acc < $past(acc))));

  // R5: lane 0 write lands in the low byte
  p_lane_lo_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en[0] |=> (inc[LANE_W-1:0] == $past(wr_data)));

  // R5: lane 1 write lands in the next byte
  p_lane_hi_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en[1] |=> (inc[2*LANE_W-1:LANE_W] == $past(wr_data)));

  // R5: a byte with no strobe keeps its value
  p_lane_keep_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en[0] |=> $stable(inc[LANE_W-1:0]));
endmodule

bind bacc_tick_gen bacc_tick_gen_chk #(.W(W), .LANE_W(LANE_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .enable     (enable),
  .phase_clr  (phase_clr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .tick       (tick),
  .inc        (inc_w),
  .acc        (acc_w)
);

// File: tb/sim_bacc_tick_gen.sv
`timescale 1ns/1ps
module sim_bacc_tick_gen;
  logic       clk;
  logic       rst_n;
  logic       enable;
  logic       phase_clr;
  logic [1:0] wr_en;
  logic [7:0] wr_data;
  logic       tick;

  int checks;
  int failures;
  int tick_cnt;
  bit done;

  logic [15:0] m_acc;
  logic [15:0] m_inc;
  logic        m_tick;

  bacc_tick_gen u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .phase_clr (phase_clr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .tick      (tick)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [15:0] baud_step(input longint baud, input longint fclk);
    return 16'((baud * 64'd1048576) / fclk);
  endfunction

  function automatic int expect_ticks(input longint n, input longint step);
    return int'((n * step) / 64'd65536);
  endfunction

  task automatic check_bit(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_int(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic model_edge(input logic e, input logic c, input logic [1:0] we,
                            input logic [7:0] d);
    logic [16:0] s;
    if (!e || c) begin
      m_acc  = '0;
      m_tick = 1'b0;
    end else begin
      s      = {1'b0, m_acc} + {1'b0, m_inc};
      m_tick = s[16];
      m_acc  = s[15:0];
    end
    if (we[0]) m_inc[7:0]  = d;
    if (we[1]) m_inc[15:8] = d;
  endtask

  // One clock: drive after negedge, model the edge, sample at next negedge.
  task automatic cyc(input logic e, input logic c, input logic [1:0] we,
                     input logic [7:0] d, input string tag);
    enable    = e;
    phase_clr = c;
    wr_en     = we;
    wr_data   = d;
    @(posedge clk);
    model_edge(e, c, we, d);
    @(negedge clk);
    check_bit(tick, m_tick, tag);
    if (tick) tick_cnt++;
  endtask

  task automatic load_step(input logic [15:0] v);
    cyc(1'b0, 1'b0, 2'b01, v[7:0],  "R5 load lo");
    cyc(1'b0, 1'b0, 2'b10, v[15:8], "R5 load hi");
  endtask

  task automatic run_count(input int n, input string tag);
    tick_cnt = 0;
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'b00, 8'h00, tag);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] st;
    logic [1:0]  rw;
    void'($urandom(32'd20240611));
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; enable = 1'b0; phase_clr = 1'b0; wr_en = 2'b00; wr_data = 8'h00;
    m_acc = '0; m_inc = '0; m_tick = 1'b0;
    repeat (3) @(negedge clk);
    check_bit(tick, 1'b0, "R1 tick low in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit(tick, 1'b0, "R1 tick low after reset");

    // R1 / R7: step is zero out of reset, so an enabled run gives nothing
    run_count(300, "R7 zero step");
    check_int(tick_cnt, 0, "R7 tick count with zero step (R1 step reset)");

    // R5: two lane writes, then overwrite only the low byte
    load_step(16'h1234);
    cyc(1'b0, 1'b0, 2'b01, 8'h00, "R5 lo only");
    run_count(4096, "R5 run");
    check_int(tick_cnt, expect_ticks(4096, 16'h1200), "R5 high byte kept");

    // R9: real baud setting
    st = baud_step(115200, 100000000);
    check_int(int'(st), 1207, "R9 step for 115200");
    load_step(st);
    run_count(65536, "R9 run");
    check_int(tick_cnt, 1207, "R9 ticks per 2^16 cycles");

    // R8: largest step
    load_step(16'hFFFF);
    run_count(65536, "R8 run");
    check_int(tick_cnt, 65535, "R8 ticks with step 0xFFFF");

    // R3: disable mid-run, then restart from zero phase with step 0x8000
    load_step(16'h8000);
    run_count(3, "R3 pre");
    cyc(1'b0, 1'b0, 2'b00, 8'h00, "R3 disabled cycle");
    check_bit(tick, 1'b0, "R3 tick low while disabled");
    run_count(10, "R3 post");
    check_int(tick_cnt, 5, "R3 restart from zero phase");

    // R4: phase restart while enabled, step 0x5555
    load_step(16'h5555);
    run_count(2, "R4 pre");
    cyc(1'b1, 1'b1, 2'b00, 8'h00, "R4 clear cycle");
    check_bit(tick, 1'b0, "R4 tick low on clear");
    run_count(3, "R4 post");
    check_int(tick_cnt, 0, "R4 phase was restarted");
    run_count(1, "R4 wrap");
    check_int(tick_cnt, 1, "R4 first carry after four steps");

    // R6: step change mid-run takes effect one edge later, phase kept
    load_step(16'h4000);
    run_count(3, "R6 pre");
    check_int(tick_cnt, 0, "R6 no carry before change");
    cyc(1'b1, 1'b0, 2'b10, 8'h20, "R6 write edge");
    check_bit(tick, 1'b1, "R6 write edge still adds old step");
    cyc(1'b1, 1'b0, 2'b00, 8'h00, "R6 after 1");
    check_bit(tick, 1'b0, "R6 new step after 1");
    cyc(1'b1, 1'b0, 2'b00, 8'h00, "R6 after 2");
    check_bit(tick, 1'b0, "R6 new step after 2");

    // R2: random mix compared against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      rw = (($urandom % 20) == 0) ? 2'(($urandom % 3) + 1) : 2'b00;
      cyc(($urandom % 10) != 0, ($urandom % 33) == 0, rw, 8'($urandom),
          "R2 random cycle");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule